// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block decides when and in what order a single multiplexed analog-to-digital converter samples its inputs. It holds sixteen conversion slots. Each slot is programmed with the trigger that arms it, the analog channel it measures, and the length of its sampling window. A slot becomes pending when its trigger fires or when software forces it. Pending slots are then serviced one at a time. A programmable threshold splits the slots into a fixed-priority group and a round-robin group.

For each slot it grants, the sequencer steers the analog mux to the slot's channel and holds the sample window open for the programmed length. It then pulses the converter start and waits for the converter's done strobe. The returned code is stored in that slot's own result register, which can be read back at any time.

A bank of interrupt lines watches the conversions. Each line is tied to one slot and can fire either when that slot's sampling ends (early mode) or when its result arrives. Each line can also fire on every event or only once until it is re-armed. A second trigger for a slot that is still waiting sets a sticky overflow flag for that slot, and the slot is converted only once.

Top module: `sq_conv_sequencer`

## Requirements
- R1: After reset, `adc_sample`, `adc_start`, every `irq` bit and every `ovf_flags` bit are 0, and every result register reads 0.
- R2: A write to address s (0 to 15) programs slot s. In that write, `cfg_wdata[3:0]` is the channel, `[7:4]` is the trigger select and `[13:8]` is the acquisition length. While slot s is being converted, `adc_chan` carries that channel.
- R3: A trigger select of k (1 to NUM_TRIG) makes a high `trig_in[k-1]` at a clock edge mark the slot pending, and a select of 0 ignores all trigger inputs. A write to address 18 marks pending every slot whose bit is set in `cfg_wdata[15:0]`.
- R4: A granted slot with acquisition length A holds `adc_sample` high for exactly A+1 cycles. It then holds `adc_start` high for exactly one cycle, and the sequencer waits for `adc_done` before it grants the next slot.
- R5: The `adc_data` value accepted with `adc_done` is stored in the granted slot's result register. `rd_data` shows the result register that `rd_addr` selects. Slots that have not been converted keep 0.
- R6: A write to address 16 sets a threshold P in `cfg_wdata[4:0]`. Pending slots numbered below P win before any other slot, and among them the lowest number wins, even when the other slot has been waiting longer.
- R7: Slots numbered P and above are served round-robin. The search starts at the slot after the last round-robin slot that was granted, and wraps from 15 to 0. After reset the search starts at slot 0.
- R8: A trigger for a slot that is already pending sets that slot's bit in `ovf_flags`, and the slot is converted only once. A write to address 17 clears the `ovf_flags` bits that are set in `cfg_wdata[15:0]`.
- R9: A write to address 32+i programs interrupt line i. The fields are source slot `[3:0]`, early `[4]`, continuous `[5]` and enable `[6]`. An enabled line goes high for one cycle. In early mode that cycle is the `adc_start` cycle of its slot. Otherwise it is the cycle after its slot's `adc_done`.
- R10: A line with continuous cleared fires once and then stays silent until its configuration is written again. A line with continuous set fires on every event of its slot.
- R11: A trigger that arrives while its own slot is being sampled or converted is not an overflow. It leads to one further conversion of that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | NUM_TRIG | Hardware trigger inputs, sampled at each edge |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| rd_addr | input | 4 | Result register select |
| rd_data | output | RES_W | Selected result register |
| ovf_flags | output | 16 | Sticky per-slot trigger overflow flags |
| adc_chan | output | 4 | Analog mux channel |
| adc_sample | output | 1 | Sample window open |
| adc_start | output | 1 | One-cycle converter start |
| adc_done | input | 1 | Converter result valid strobe |
| adc_data | input | RES_W | Converter result |
| irq | output | NUM_IRQ | Interrupt line pulses |

## Verification
A corrupted pending vector or round-robin pointer shows up as a wrong channel order on `adc_chan` at the following `adc_start` pulses. The bench logs that order conversion by conversion, so the error appears within one conversion of the fault. A miscounted window shows up as an `adc_sample` run of the wrong length at the very next grant. A wrong arming bit on an interrupt line shows up as a missing or extra `irq` pulse at the line's next event. A lost overflow update is visible on `ovf_flags` in the cycle after the second trigger.

// File: rtl/sq_pkg.sv
package sq_pkg;

    localparam int NSLOT  = 16;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int PRI_W  = SLOT_W + 1;
    localparam int CH_W   = 4;
    localparam int TSEL_W = 4;
    localparam int ACQ_W  = 6;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 6;
    localparam int ICFG_W = SLOT_W + 3;

    localparam logic [ADDR_W-1:0] A_HIPRI  = 6'd16;
    localparam logic [ADDR_W-1:0] A_OVFCLR = 6'd17;
    localparam logic [ADDR_W-1:0] A_FORCE  = 6'd18;
    localparam logic [ADDR_W-1:0] A_IRQ0   = 6'd32;

    typedef struct packed {
        logic [ACQ_W-1:0]  acq;
        logic [TSEL_W-1:0] tsel;
        logic [CH_W-1:0]   chan;
    } slot_cfg_t;

    typedef struct packed {
        logic              en;
        logic              cont;
        logic              early;
        logic [SLOT_W-1:0] slot;
    } irq_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_START,
        ST_WAIT
    } seq_state_t;

    function automatic slot_cfg_t to_slot_cfg(input logic [REG_W-1:0] d);
        slot_cfg_t c;
        c.chan = d[CH_W-1:0];
        c.tsel = d[CH_W+TSEL_W-1:CH_W];
        c.acq  = d[CH_W+TSEL_W+ACQ_W-1:CH_W+TSEL_W];
        return c;
    endfunction

    function automatic irq_cfg_t to_irq_cfg(input logic [ICFG_W-1:0] d);
        irq_cfg_t c;
        c.slot  = d[SLOT_W-1:0];
        c.early = d[SLOT_W];
        c.cont  = d[SLOT_W+1];
        c.en    = d[SLOT_W+2];
        return c;
    endfunction

endpackage

// File: rtl/sq_slot_bank.sv
module sq_slot_bank
    import sq_pkg::*;
#(
    parameter int NUM_TRIG = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic                take_fire,
    input  logic [SLOT_W-1:0]   take_idx,
    output slot_cfg_t           cfg [NSLOT],
    output logic [NSLOT-1:0]    pend,
    output logic [NSLOT-1:0]    ovf,
    output logic [PRI_W-1:0]    hipri
);

    logic [NSLOT-1:0] hit;
    logic [NSLOT-1:0] take;
    logic [NSLOT-1:0] clr;
    logic             wr_slot;

    assign wr_slot = we && (addr < ADDR_W'(NSLOT));

    always_comb begin
        hit = '0;
        for (int s = 0; s < NSLOT; s++) begin
            for (int k = 0; k < NUM_TRIG; k++) begin
                if (cfg[s].tsel == TSEL_W'(k + 1) && trig_in[k]) hit[s] = 1'b1;
            end
            if (we && addr == A_FORCE && wdata[s]) hit[s] = 1'b1;
        end
        take = take_fire ? ({{(NSLOT-1){1'b0}}, 1'b1} << take_idx) : '0;
        clr  = (we && addr == A_OVFCLR) ? wdata[NSLOT-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            ovf   <= '0;
            hipri <= '0;
            for (int s = 0; s < NSLOT; s++) cfg[s] <= '0;
        end else begin
            pend <= (pend & ~take) | hit;
            ovf  <= (ovf & ~clr) | (hit & pend & ~take);
            if (we && addr == A_HIPRI) hipri <= wdata[PRI_W-1:0];
            if (wr_slot) cfg[addr[SLOT_W-1:0]] <= to_slot_cfg(wdata);
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_chk
        assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (rst)
            $rose(ovf[s]) |-> $past(pend[s]));
        assert_pend_kept_R8: assert property (@(posedge clk) disable iff (rst)
            ($past(pend[s]) && !$past(take[s])) |-> pend[s]);
    end

endmodule

// File: rtl/sq_arbiter.sv
module sq_arbiter
    import sq_pkg::*;
(
    input  logic [NSLOT-1:0]  pend,
    input  logic [PRI_W-1:0]  hipri,
    input  logic [SLOT_W-1:0] rr_ptr,
    output logic              gvalid,
    output logic [SLOT_W-1:0] gidx
);

    logic [SLOT_W-1:0] probe;

    always_comb begin
        gvalid = 1'b0;
        gidx   = '0;
        probe  = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (!gvalid && PRI_W'(s) < hipri && pend[s]) begin
                gvalid = 1'b1;
                gidx   = SLOT_W'(s);
            end
        end
        for (int k = 0; k < NSLOT; k++) begin
            probe = rr_ptr + SLOT_W'(k);
            if (!gvalid && {1'b0, probe} >= hipri && pend[probe]) begin
                gvalid = 1'b1;
                gidx   = probe;
            end
        end
    end

endmodule

// File: rtl/sq_irq_bank.sv
module sq_irq_bank
    import sq_pkg::*;
#(
    parameter int NUM_IRQ = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ICFG_W-1:0]  wdata,
    input  logic               eos_evt,
    input  logic               eoc_evt,
    input  logic [SLOT_W-1:0]  evt_slot,
    output logic [NUM_IRQ-1:0] irq
);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        irq_cfg_t lcfg;
        logic     armed;
        logic     pulse;
        logic     hit;
        logic     wr;

        assign wr  = we && (addr == A_IRQ0 + ADDR_W'(i));
        assign hit = lcfg.en && armed && (lcfg.slot == evt_slot)
                   && (lcfg.early ? eos_evt : eoc_evt);

        always_ff @(posedge clk) begin
            if (rst) begin
                lcfg  <= '0;
                armed <= 1'b1;
                pulse <= 1'b0;
            end else begin
                pulse <= hit;
                if (wr) begin
                    lcfg  <= to_irq_cfg(wdata);
                    armed <= 1'b1;
                end else if (hit && !lcfg.cont) begin
                    armed <= 1'b0;
                end
            end
        end

        assign irq[i] = pulse;

        assert_oneshot_R10: assert property (@(posedge clk) disable iff (rst)
            (pulse && !lcfg.cont && !$past(wr)) |-> !armed);
        assert_irq_enabled_R9: assert property (@(posedge clk) disable iff (rst)
            pulse |-> $past(lcfg.en));
        assert_irq_single_R9: assert property (@(posedge clk) disable iff (rst)
            pulse |=> !pulse);
    end

endmodule

// File: rtl/sq_conv_sequencer.sv
module sq_conv_sequencer
    import sq_pkg::*;
#(
    parameter int NUM_TRIG = 4,
    parameter int NUM_IRQ  = 9,
    parameter int RES_W    = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [REG_W-1:0]    cfg_wdata,
    input  logic [SLOT_W-1:0]   rd_addr,
    output logic [RES_W-1:0]    rd_data,
    output logic [NSLOT-1:0]    ovf_flags,
    output logic [CH_W-1:0]     adc_chan,
    output logic                adc_sample,
    output logic                adc_start,
    input  logic                adc_done,
    input  logic [RES_W-1:0]    adc_data,
    output logic [NUM_IRQ-1:0]  irq
);

    slot_cfg_t         cfg [NSLOT];
    logic [NSLOT-1:0]  pend;
    logic [PRI_W-1:0]  hipri;
    logic              gvalid;
    logic [SLOT_W-1:0] gidx;
    logic              gfire;
    seq_state_t        state;
    logic [ACQ_W-1:0]  cnt;
    logic [SLOT_W-1:0] cur;
    logic [SLOT_W-1:0] rr_ptr;
    logic [RES_W-1:0]  results [NSLOT];
    logic              eos_evt;
    logic              eoc_evt;
    logic [NSLOT-1:0]  primask;

    assign gfire = (state == ST_IDLE) && gvalid;

    sq_slot_bank #(.NUM_TRIG(NUM_TRIG)) u_slots (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .trig_in   (trig_in),
        .take_fire (gfire),
        .take_idx  (gidx),
        .cfg       (cfg),
        .pend      (pend),
        .ovf       (ovf_flags),
        .hipri     (hipri)
    );

    sq_arbiter u_arb (
        .pend   (pend),
        .hipri  (hipri),
        .rr_ptr (rr_ptr),
        .gvalid (gvalid),
        .gidx   (gidx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            cur    <= '0;
            rr_ptr <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (gvalid) begin
                        cur   <= gidx;
                        cnt   <= cfg[gidx].acq;
                        state <= ST_SAMPLE;
                        if ({1'b0, gidx} >= hipri) rr_ptr <= gidx + SLOT_W'(1);
                    end
                end
                ST_SAMPLE: begin
                    if (cnt == '0) state <= ST_START;
                    else           cnt   <= cnt - ACQ_W'(1);
                end
                ST_START: state <= ST_WAIT;
                ST_WAIT:  if (adc_done) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSLOT; s++) results[s] <= '0;
        end else if (eoc_evt) begin
            results[cur] <= adc_data;
        end
    end

    assign adc_sample = (state == ST_SAMPLE);
    assign adc_start  = (state == ST_START);
    assign adc_chan   = cfg[cur].chan;
    assign eos_evt    = (state == ST_SAMPLE) && (cnt == '0);
    assign eoc_evt    = (state == ST_WAIT) && adc_done;
    assign rd_data    = results[rd_addr];

    sq_irq_bank #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata[ICFG_W-1:0]),
        .eos_evt  (eos_evt),
        .eoc_evt  (eoc_evt),
        .evt_slot (cur),
        .irq      (irq)
    );

    always_comb begin
        for (int s = 0; s < NSLOT; s++) primask[s] = PRI_W'(s) < hipri;
    end

    assert_grant_pending_R6: assert property (@(posedge clk) disable iff (rst)
        gfire |-> pend[gidx]);
    assert_pri_first_R6: assert property (@(posedge clk) disable iff (rst)
        (gfire && |(pend & primask)) |-> ({1'b0, gidx} < hipri));
    assert_start_after_sample_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_sample) |-> adc_start);
    assert_start_single_R4: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);
    assert_phase_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(adc_sample && adc_start));
    assert_hold_chan_R2: assert property (@(posedge clk) disable iff (rst)
        (adc_start && !$past(cfg_we)) |-> $stable(adc_chan));

endmodule

// File: tb/sim_sq_conv_sequencer.sv
module sim_sq_conv_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int NI = 9;
    localparam int RW = 12;

    // arbitration table: threshold, force mask, expected channel order
    localparam int NV = 4;
    localparam logic [4:0]  V_HP   [NV] = '{5'd0, 5'd4, 5'd16, 5'd2};
    localparam logic [15:0] V_MASK [NV] = '{16'h2421, 16'h108C, 16'h8212, 16'h010B};
    localparam logic [3:0]  V_ORD  [NV][4] = '{
        '{4'd0, 4'd5, 4'd10, 4'd13},
        '{4'd2, 4'd3, 4'd7,  4'd12},
        '{4'd1, 4'd4, 4'd9,  4'd15},
        '{4'd0, 4'd1, 4'd3,  4'd8}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NT-1:0] trig_in = '0;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic [3:0]    rd_addr = '0;
    logic [RW-1:0] rd_data;
    logic [15:0]   ovf_flags;
    logic [3:0]    adc_chan;
    logic          adc_sample;
    logic          adc_start;
    logic          adc_done = 1'b0;
    logic [RW-1:0] adc_data = '0;
    logic [NI-1:0] irq;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    // converter model and port monitor
    int mcnt = 0;
    int nlog = 0;
    logic [3:0] logc [256];
    logic [3:0] lat_chan = '0;
    int nconv = 0;
    int run = 0;
    int last_run = 0;
    int seq_bad = 0;
    int early_hits = 0;
    int norm_hits = 0;
    int icnt [NI];
    bit prev_sample = 0;
    bit prev_start = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sq_conv_sequencer #(.NUM_TRIG(NT), .NUM_IRQ(NI), .RES_W(RW)) u0 (
        .clk(clk), .rst(rst), .trig_in(trig_in), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_addr(rd_addr),
        .rd_data(rd_data), .ovf_flags(ovf_flags), .adc_chan(adc_chan),
        .adc_sample(adc_sample), .adc_start(adc_start), .adc_done(adc_done),
        .adc_data(adc_data), .irq(irq)
    );

    initial for (int k = 0; k < NI; k++) icnt[k] = 0;

    always @(negedge clk) begin
        adc_done <= 1'b0;
        if (!rst) begin
            for (int k = 0; k < NI; k++) icnt[k] = icnt[k] + int'(irq[k]);
            if (irq[0] && adc_start) early_hits++;
            if (irq[3] && adc_done) norm_hits++;
            if (adc_sample) run++;
            if (adc_start) begin
                if (!prev_sample || prev_start) seq_bad++;
                last_run = run;
                run = 0;
                lat_chan = adc_chan;
                logc[nlog[7:0]] = adc_chan;
                nlog++;
                nconv++;
                mcnt = 2;
            end else if (mcnt == 2) begin
                mcnt = 1;
            end else if (mcnt == 1) begin
                mcnt = 0;
                adc_done <= 1'b1;
                adc_data <= {lat_chan, 8'(nconv)};
            end
        end else begin
            mcnt = 0;
            run = 0;
        end
        prev_sample = adc_sample;
        prev_start = adc_start;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 6'(a);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        trig_in[k] = 1'b1;
        @(negedge clk);
        trig_in[k] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [15:0] mk(input int ch, input int ts, input int acq);
        return {2'b00, 6'(acq), 4'(ts), 4'(ch)};
    endfunction

    task automatic cfg_all();
        for (int s = 0; s < 16; s++) wr(s, mk(s, 0, 0));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_res(input int s, output logic [RW-1:0] v);
        @(negedge clk);
        rd_addr = 4'(s);
        #1;
        v = rd_data;
    endtask

    initial begin
        int base;
        int b0, b1, b2, e0, n0;
        logic [RW-1:0] rv;

        // R1: reset state
        do_reset();
        #1;
        chk(adc_sample == 1'b0 && adc_start == 1'b0, "R1 phase idle", int'({adc_sample, adc_start}), 0);
        chk(irq == '0, "R1 irq low", int'(irq), 0);
        chk(ovf_flags == '0, "R1 ovf clear", int'(ovf_flags), 0);
        read_res(0, rv);
        chk(rv == '0, "R1 result zero", int'(rv), 0);

        // R6 R7: table of arbitration vectors
        for (int v = 0; v < NV; v++) begin
            do_reset();
            cfg_all();
            wr(16, {11'd0, V_HP[v]});
            base = nlog;
            wr(18, V_MASK[v]);
            idle(80);
            chk(nlog - base == 4, "R6 R7 table count", nlog - base, 4);
            for (int j = 0; j < 4; j++)
                chk(logc[8'(base + j)] == V_ORD[v][j], "R6 R7 table order",
                    int'(logc[8'(base + j)]), int'(V_ORD[v][j]));
        end

        // R7: pointer continues after last round-robin grant
        do_reset();
        cfg_all();
        wr(18, 16'h0008);
        idle(30);
        base = nlog;
        wr(18, 16'h0042);
        idle(40);
        chk(logc[8'(base)] == 4'd6, "R7 after slot 3 pick 6", int'(logc[8'(base)]), 6);
        chk(logc[8'(base + 1)] == 4'd1, "R7 wrap to 1", int'(logc[8'(base + 1)]), 1);

        // R6: late priority slot overtakes waiting round-robin slot
        do_reset();
        cfg_all();
        wr(9, mk(9, 0, 10));
        wr(16, 16'd4);
        base = nlog;
        wr(18, 16'h1200);
        idle(3);
        wr(18, 16'h0002);
        idle(80);
        chk(logc[8'(base)] == 4'd9, "R6 first", int'(logc[8'(base)]), 9);
        chk(logc[8'(base + 1)] == 4'd1, "R6 priority overtakes", int'(logc[8'(base + 1)]), 1);
        chk(logc[8'(base + 2)] == 4'd12, "R6 rr last", int'(logc[8'(base + 2)]), 12);

        // R4 R9 R2 R5: window length and interrupt timing
        do_reset();
        cfg_all();
        wr(5, mk(5, 0, 3));
        wr(32, 16'h0075);
        wr(35, 16'h0065);
        b0 = icnt[0]; e0 = early_hits; n0 = norm_hits; b1 = seq_bad;
        base = nlog;
        wr(18, 16'h0020);
        idle(40);
        chk(last_run == 4, "R4 sample window A+1", last_run, 4);
        chk(seq_bad == b1, "R4 start single after sample", seq_bad - b1, 0);
        chk(early_hits - e0 == 1, "R9 early irq at start", early_hits - e0, 1);
        chk(norm_hits - n0 == 1, "R9 normal irq after done", norm_hits - n0, 1);
        chk(icnt[0] - b0 == 1, "R9 one pulse", icnt[0] - b0, 1);
        chk(logc[8'(base)] == 4'd5, "R2 channel driven", int'(logc[8'(base)]), 5);
        read_res(5, rv);
        chk(rv[11:8] == 4'd5, "R5 result stored", int'(rv[11:8]), 5);
        read_res(6, rv);
        chk(rv == '0, "R5 untouched slot", int'(rv), 0);
        wr(11, mk(3, 0, 0));
        base = nlog;
        wr(18, 16'h0800);
        idle(30);
        chk(logc[8'(base)] == 4'd3, "R2 reprogrammed channel", int'(logc[8'(base)]), 3);
        read_res(11, rv);
        chk(rv[11:8] == 4'd3, "R5 slot 11 result", int'(rv[11:8]), 3);

        // R10: single-shot versus continuous
        wr(33, 16'h0044);
        wr(34, 16'h0064);
        b1 = icnt[1]; b2 = icnt[2];
        wr(18, 16'h0010);
        idle(30);
        wr(18, 16'h0010);
        idle(30);
        chk(icnt[1] - b1 == 1, "R10 single-shot once", icnt[1] - b1, 1);
        chk(icnt[2] - b2 == 2, "R10 continuous each", icnt[2] - b2, 2);
        wr(33, 16'h0044);
        wr(18, 16'h0010);
        idle(30);
        chk(icnt[1] - b1 == 2, "R10 rearmed", icnt[1] - b1, 2);
        chk(icnt[2] - b2 == 3, "R10 continuous third", icnt[2] - b2, 3);

        // R8: overflow on double trigger
        do_reset();
        cfg_all();
        wr(0, mk(0, 0, 20));
        wr(2, mk(2, 1, 0));
        wr(7, mk(7, 3, 0));
        base = nconv;
        wr(18, 16'h0001);
        idle(3);
        pulse(0);
        pulse(0);
        #1;
        chk(ovf_flags == 16'h0004, "R8 overflow flag", int'(ovf_flags), 4);
        idle(80);
        chk(nconv - base == 2, "R8 converted once", nconv - base, 2);
        wr(17, 16'h0004);
        #1;
        chk(ovf_flags == 16'h0000, "R8 overflow cleared", int'(ovf_flags), 0);

        // R11: retrigger during own conversion
        wr(2, mk(2, 1, 10));
        base = nconv;
        pulse(0);
        idle(4);
        pulse(0);
        #1;
        chk(ovf_flags == 16'h0000, "R11 no overflow", int'(ovf_flags), 0);
        idle(80);
        chk(nconv - base == 2, "R11 second conversion", nconv - base, 2);

        // R3: trigger selection
        base = nconv;
        pulse(1);
        idle(30);
        chk(nconv - base == 0, "R3 unselected trigger ignored", nconv - base, 0);
        n0 = nlog;
        pulse(2);
        idle(30);
        chk(nconv - base == 1, "R3 selected trigger", nconv - base, 1);
        chk(logc[8'(n0)] == 4'd7, "R3 slot 7 channel", int'(logc[8'(n0)]), 7);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule